// File: doc/BRIEF.md
# Pipelined Q1.15 Multiply-Accumulate Unit

This block multiplies two 18-bit operands and folds the product into a 52-bit running sum. Each operand has its own signed/unsigned select. The product can be rounded and/or clamped to the Q1.15 range before it reaches the accumulator. Each cycle the product is added to or subtracted from the sum. A load control restarts the sum from a preset value built from an upper-data input. A second round/clamp stage shapes the visible output word without disturbing the internal running sum. An overflow flag and two saturation flags leave the block in the same cycle as the data word they describe.

The pipeline has three register ranks: operand capture, product, and accumulator/output. With the default control staging, every control belonging to one operand pair is presented together with that pair. A clock enable freezes the whole pipeline. An active-low asynchronous reset clears every register. Narrower operands are used by zeroing their unused low-order bits.

Top module: `mult_acc_unit`

## Requirements
- R1: While rst_ni is low, data_o, overflow_o, prod_sat_o and acc_sat_o are all zero, and all pipeline registers and the running sum are cleared.
- R2: Operands and controls presented before enabled clock edge k are reflected in the outputs after enabled edge k+2 (default parameters: accumulator controls staged twice, product controls once). With no rounding or clamping, data_o is the new running sum, modulo 2^52.
- R3: When sub_i is 1 the product is subtracted from the running sum; when it is 0 the product is added.
- R4: When load_i is 1 the previous sum is discarded. The new sum is the preset value ± product, where the preset has load_upper_i in bits 51:34 and zeros below. The preset is sign-extended when either sign control is 1.
- R5: When prod_round_i is 1, the product gets 2^14 added and then bits 14:0 cleared (round half up at Q1.15 resolution).
- R6: When prod_sat_i is 1, a (possibly rounded) product above 2^30-2^15 becomes 2^30-2^15, and one below -2^30 becomes -2^30. prod_sat_o is 1 in exactly the cycle whose data_o includes that clamped product.
- R7: acc_round_i and acc_sat_i apply the same rounding and limits to the new sum for data_o only. The running sum keeps its unrounded, unclamped value. acc_sat_o is 1 with the clamped word.
- R8: overflow_o rises when the true new sum leaves the 52-bit range. The range is signed when either sign control is 1, and unsigned otherwise. The flag stays set until a load cycle, which sets it to that cycle's own overflow result.
- R9: While ena_i is 0, no register changes and all outputs hold.
- R10: sign_a_i and sign_b_i independently select two's-complement or unsigned interpretation of a_i and b_i, so mixed-sign products are formed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low clear |
| ena_i | input | 1 | Clock enable for every register |
| a_i | input | 18 | Operand A |
| b_i | input | 18 | Operand B |
| sign_a_i | input | 1 | Operand A is two's complement |
| sign_b_i | input | 1 | Operand B is two's complement |
| sub_i | input | 1 | Subtract product instead of adding |
| load_i | input | 1 | Restart sum from preset |
| load_upper_i | input | 18 | Preset bits 51:34 |
| prod_round_i | input | 1 | Round product at Q1.15 |
| prod_sat_i | input | 1 | Clamp product to Q1.15 range |
| acc_round_i | input | 1 | Round output word at Q1.15 |
| acc_sat_i | input | 1 | Clamp output word to Q1.15 range |
| data_o | output | 52 | Shaped accumulator result |
| overflow_o | output | 1 | Sticky sum overflow |
| prod_sat_o | output | 1 | Product clamp flag, aligned with data_o |
| acc_sat_o | output | 1 | Output clamp flag, aligned with data_o |

## Verification
The bench builds the unit with its default parameters: 18-bit operands, a 52-bit sum, an 18-bit preset, two staging registers on the accumulator controls and one on the product controls. In that setting, every control of an operand pair travels with the pair. A queue-based model can therefore retire one transaction per enabled edge and compare all four outputs every cycle. Because the preset lands in the top 18 bits, signed and unsigned overflow can be reached within one or two products. Extreme operand pairs reach both clamp limits in both rounding stages.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic load;
    logic sub;
    logic rnd;
    logic sat;
    logic sa;
    logic sb;
  } acc_ctrl_t;

  typedef struct packed {
    logic rnd;
    logic sat;
  } mul_ctrl_t;

  localparam int unsigned ACC_CTRL_W = $bits(acc_ctrl_t);
  localparam int unsigned MUL_CTRL_W = $bits(mul_ctrl_t);
endpackage

// File: rtl/mac_q115_rs.sv
module mac_q115_rs #(
  parameter int unsigned W      = 38,
  parameter int unsigned FRAC_W = 15
) (
  input  logic signed [W-1:0] val_i,
  input  logic                rnd_i,
  input  logic                sat_i,
  output logic signed [W-1:0] res_o,
  output logic                sat_o
);
  localparam logic signed [W-1:0] ONE     = W'(1);
  localparam logic signed [W-1:0] HALF    = ONE <<< (FRAC_W - 1);
  localparam logic signed [W-1:0] LOW     = (ONE <<< FRAC_W) - ONE;
  localparam logic signed [W-1:0] MAX_POS = ((ONE <<< FRAC_W) - ONE) <<< FRAC_W;
  localparam logic signed [W-1:0] MIN_NEG = -(ONE <<< (2 * FRAC_W));

  logic signed [W-1:0] rounded;

  always_comb begin
    rounded = rnd_i ? ((val_i + HALF) & ~LOW) : val_i;
    res_o   = rounded;
    sat_o   = 1'b0;
    if (sat_i) begin
      if (rounded > MAX_POS) begin
        res_o = MAX_POS;
        sat_o = 1'b1;
      end else if (rounded < MIN_NEG) begin
        res_o = MIN_NEG;
        sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac_dly.sv
module mac_dly #(
  parameter int unsigned W = 1,
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (N == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_pipe
      logic [W-1:0] stg [N];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < N; i++) stg[i] <= '0;
        end else if (en_i) begin
          stg[0] <= d_i;
          for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
        end
      end
      assign q_o = stg[N-1];
    end
  endgenerate
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage #(
  parameter int unsigned A_W    = 18,
  parameter int unsigned B_W    = 18,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned P_W   = A_W + B_W + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [A_W-1:0]        a_i,
  input  logic [B_W-1:0]        b_i,
  input  logic                  sa_i,
  input  logic                  sb_i,
  input  logic                  rnd_i,
  input  logic                  sat_i,
  output logic signed [P_W-1:0] p_o,
  output logic                  psat_o
);
  localparam logic signed [P_W-1:0] ONE     = P_W'(1);
  localparam logic signed [P_W-1:0] MAX_POS = ((ONE <<< FRAC_W) - ONE) <<< FRAC_W;
  localparam logic signed [P_W-1:0] MIN_NEG = -(ONE <<< (2 * FRAC_W));

  logic [A_W-1:0]        a_q;
  logic [B_W-1:0]        b_q;
  logic                  sa_q, sb_q;
  logic signed [P_W-1:0] a_w, b_w, prod, shaped;
  logic                  shaped_sat;
  logic signed [P_W-1:0] p_q;
  logic                  psat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      sa_q <= 1'b0;
      sb_q <= 1'b0;
    end else if (en_i) begin
      a_q  <= a_i;
      b_q  <= b_i;
      sa_q <= sa_i;
      sb_q <= sb_i;
    end
  end

  // sign- or zero-extend each operand on its own select
  always_comb begin
    a_w  = {{(P_W-A_W){sa_q & a_q[A_W-1]}}, a_q};
    b_w  = {{(P_W-B_W){sb_q & b_q[B_W-1]}}, b_q};
    prod = a_w * b_w;
  end

  mac_q115_rs #(.W(P_W), .FRAC_W(FRAC_W)) u_prod_rs (
    .val_i (prod),
    .rnd_i (rnd_i),
    .sat_i (sat_i),
    .res_o (shaped),
    .sat_o (shaped_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= '0;
      psat_q <= 1'b0;
    end else if (en_i) begin
      p_q    <= shaped;
      psat_q <= shaped_sat;
    end
  end

  assign p_o    = p_q;
  assign psat_o = psat_q;

  a_r5_prod_round_clears_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rnd_i) |=> (p_q[FRAC_W-1:0] == '0));

  a_r6_prod_sat_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psat_q |-> (p_q == MAX_POS || p_q == MIN_NEG));
endmodule

// File: rtl/mac_accum_stage.sv
module mac_accum_stage
  import mac_pkg::*;
#(
  parameter int unsigned ACC_W  = 52,
  parameter int unsigned UP_W   = 18,
  parameter int unsigned P_W    = 38,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned S_W   = ACC_W + 2,
  localparam int unsigned UP_SH = ACC_W - UP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic signed [P_W-1:0] p_i,
  input  logic                  psat_i,
  input  acc_ctrl_t             ctrl_i,
  input  logic [UP_W-1:0]       upper_i,
  output logic [ACC_W-1:0]      data_o,
  output logic                  ovf_o,
  output logic                  psat_o,
  output logic                  asat_o
);
  localparam logic signed [S_W-1:0] ONE     = S_W'(1);
  localparam logic signed [S_W-1:0] MAX_POS = ((ONE <<< FRAC_W) - ONE) <<< FRAC_W;
  localparam logic signed [S_W-1:0] MIN_NEG = -(ONE <<< (2 * FRAC_W));

  logic [ACC_W-1:0]      acc_q, data_q;
  logic                  ovf_q, psat_q, asat_q;
  logic                  sm, ovf_now, rs_sat;
  logic signed [S_W-1:0] old, base_ld, base, pw, sum, shaped;
  logic                  unused_hi;

  always_comb begin
    sm      = ctrl_i.sa | ctrl_i.sb;
    old     = {{2{sm & acc_q[ACC_W-1]}}, acc_q};
    base_ld = {{2{sm & upper_i[UP_W-1]}}, upper_i, {UP_SH{1'b0}}};
    base    = ctrl_i.load ? base_ld : old;
    pw      = {{(S_W-P_W){p_i[P_W-1]}}, p_i};
    sum     = ctrl_i.sub ? (base - pw) : (base + pw);
    if (sm) ovf_now = !((&sum[S_W-1:ACC_W-1]) || (~|sum[S_W-1:ACC_W-1]));
    else    ovf_now = |sum[S_W-1:ACC_W];
  end

  mac_q115_rs #(.W(S_W), .FRAC_W(FRAC_W)) u_acc_rs (
    .val_i (sum),
    .rnd_i (ctrl_i.rnd),
    .sat_i (ctrl_i.sat),
    .res_o (shaped),
    .sat_o (rs_sat)
  );

  assign unused_hi = ^shaped[S_W-1:ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      data_q <= '0;
      ovf_q  <= 1'b0;
      psat_q <= 1'b0;
      asat_q <= 1'b0;
    end else if (en_i) begin
      acc_q  <= sum[ACC_W-1:0];
      data_q <= shaped[ACC_W-1:0];
      ovf_q  <= ctrl_i.load ? ovf_now : (ovf_q | ovf_now);
      psat_q <= psat_i;
      asat_q <= rs_sat;
    end
  end

  assign data_o = data_q;
  assign ovf_o  = ovf_q;
  assign psat_o = psat_q;
  assign asat_o = asat_q;

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ctrl_i.load && ovf_q) |=> ovf_q);

  a_r7_acc_sat_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asat_q |-> (data_q == MAX_POS[ACC_W-1:0] || data_q == MIN_NEG[ACC_W-1:0]));
endmodule

// File: rtl/mult_acc_unit.sv
module mult_acc_unit
  import mac_pkg::*;
#(
  parameter int unsigned A_W            = 18,
  parameter int unsigned B_W            = 18,
  parameter int unsigned ACC_W          = 52,
  parameter int unsigned UP_W           = 18,
  parameter int unsigned FRAC_W         = 15,
  parameter int unsigned ACC_CTRL_REGS  = 2,
  parameter int unsigned MULT_CTRL_REGS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ena_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic             sub_i,
  input  logic             load_i,
  input  logic [UP_W-1:0]  load_upper_i,
  input  logic             prod_round_i,
  input  logic             prod_sat_i,
  input  logic             acc_round_i,
  input  logic             acc_sat_i,
  output logic [ACC_W-1:0] data_o,
  output logic             overflow_o,
  output logic             prod_sat_o,
  output logic             acc_sat_o
);
  localparam int unsigned P_W   = A_W + B_W + 2;
  localparam int unsigned ACW_W = ACC_CTRL_W + UP_W;

  acc_ctrl_t          acc_ctrl_in, acc_ctrl_d;
  mul_ctrl_t          mul_ctrl_in, mul_ctrl_d;
  logic [UP_W-1:0]    upper_d;
  logic [ACW_W-1:0]   acw_in, acw_out;
  logic [MUL_CTRL_W-1:0] mcw_out;
  logic signed [P_W-1:0] prod_q;
  logic               prod_flag_q;

  assign acc_ctrl_in = '{load: load_i, sub: sub_i, rnd: acc_round_i,
                         sat: acc_sat_i, sa: sign_a_i, sb: sign_b_i};
  assign mul_ctrl_in = '{rnd: prod_round_i, sat: prod_sat_i};
  assign acw_in      = {acc_ctrl_in, load_upper_i};

  mac_dly #(.W(ACW_W), .N(ACC_CTRL_REGS)) u_acc_ctrl_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (ena_i),
    .d_i   (acw_in), .q_o (acw_out)
  );

  mac_dly #(.W(MUL_CTRL_W), .N(MULT_CTRL_REGS)) u_mul_ctrl_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (ena_i),
    .d_i   (mul_ctrl_in), .q_o (mcw_out)
  );

  assign acc_ctrl_d = acc_ctrl_t'(acw_out[ACW_W-1:UP_W]);
  assign upper_d    = acw_out[UP_W-1:0];
  assign mul_ctrl_d = mul_ctrl_t'(mcw_out);

  mac_mult_stage #(.A_W(A_W), .B_W(B_W), .FRAC_W(FRAC_W)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ena_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .sa_i   (sign_a_i),
    .sb_i   (sign_b_i),
    .rnd_i  (mul_ctrl_d.rnd),
    .sat_i  (mul_ctrl_d.sat),
    .p_o    (prod_q),
    .psat_o (prod_flag_q)
  );

  mac_accum_stage #(.ACC_W(ACC_W), .UP_W(UP_W), .P_W(P_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ena_i),
    .p_i     (prod_q),
    .psat_i  (prod_flag_q),
    .ctrl_i  (acc_ctrl_d),
    .upper_i (upper_d),
    .data_o  (data_o),
    .ovf_o   (overflow_o),
    .psat_o  (prod_sat_o),
    .asat_o  (acc_sat_o)
  );

  a_r9_hold_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_i |=> ($stable(data_o) && $stable(overflow_o) &&
                $stable(prod_sat_o) && $stable(acc_sat_o)));

  a_r1_flags_clear_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && !overflow_o && !prod_sat_o && !acc_sat_o));
endmodule

// File: tb/mult_acc_unit_test.sv
module mult_acc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam longint M52    = (64'sd1 <<< 52) - 1;
  localparam longint QMAX   = (64'sd1 <<< 30) - (64'sd1 <<< 15);
  localparam longint QMIN   = -(64'sd1 <<< 30);

  typedef struct {
    int a, b, up;
    bit sa, sb, sub, ld, pr, ps, ar, as;
  } txn_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ena_i = 1'b0;
  logic [17:0] a_i = '0, b_i = '0, load_upper_i = '0;
  logic        sign_a_i = 0, sign_b_i = 0, sub_i = 0, load_i = 0;
  logic        prod_round_i = 0, prod_sat_i = 0, acc_round_i = 0, acc_sat_i = 0;
  logic [51:0] data_o;
  logic        overflow_o, prod_sat_o, acc_sat_o;

  int checks = 0, fails = 0;
  bit done = 0;

  txn_t   q[$];
  longint acc_m, exp_data;
  bit     exp_ovf, exp_psat, exp_asat;

  mult_acc_unit uut (
    .clk_i, .rst_ni, .ena_i, .a_i, .b_i, .sign_a_i, .sign_b_i, .sub_i, .load_i,
    .load_upper_i, .prod_round_i, .prod_sat_i, .acc_round_i, .acc_sat_i,
    .data_o, .overflow_o, .prod_sat_o, .acc_sat_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic longint sx(longint v, int w);
    longint m = (64'sd1 <<< w) - 1;
    v = v & m;
    if (v[w-1]) v = v - (64'sd1 <<< w);
    return v;
  endfunction

  function automatic longint shape(longint v, bit rnd, bit sat, output bit f);
    f = 0;
    if (rnd) v = (v + 16384) & ~longint'(32767);
    if (sat && v > QMAX) begin v = QMAX; f = 1; end
    else if (sat && v < QMIN) begin v = QMIN; f = 1; end
    return v;
  endfunction

  function automatic txn_t mk(int a, int b, bit sa, bit sb, bit sub, bit ld, int up,
                              bit pr, bit ps, bit ar, bit as);
    txn_t t;
    t.a = a & 'h3FFFF; t.b = b & 'h3FFFF; t.up = up & 'h3FFFF;
    t.sa = sa; t.sb = sb; t.sub = sub; t.ld = ld;
    t.pr = pr; t.ps = ps; t.ar = ar; t.as = as;
    return t;
  endfunction

  task automatic model_reset();
    txn_t z = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    q = {};
    q.push_back(z);
    q.push_back(z);
    acc_m = 0; exp_data = 0; exp_ovf = 0; exp_psat = 0; exp_asat = 0;
  endtask

  task automatic retire(txn_t t);
    longint av, bv, p, old, base, sum;
    bit pf, af, sm, ovf_now;
    av = t.sa ? sx(t.a, 18) : longint'(t.a);
    bv = t.sb ? sx(t.b, 18) : longint'(t.b);
    p  = shape(av * bv, t.pr, t.ps, pf);
    sm = t.sa | t.sb;
    old  = sm ? sx(acc_m, 52) : acc_m;
    base = t.ld ? ((sm ? sx(t.up, 18) : longint'(t.up)) * (64'sd1 <<< 34)) : old;
    sum  = t.sub ? base - p : base + p;
    if (sm) ovf_now = (sum > (64'sd1 <<< 51) - 1) || (sum < -(64'sd1 <<< 51));
    else    ovf_now = (sum < 0) || (sum > M52);
    exp_ovf  = t.ld ? ovf_now : (exp_ovf | ovf_now);
    acc_m    = sum & M52;
    exp_data = shape(sum, t.ar, t.as, af) & M52;
    exp_psat = pf;
    exp_asat = af;
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) model_reset();
    else if (ena_i) begin
      txn_t t;
      t.a = int'(a_i); t.b = int'(b_i); t.up = int'(load_upper_i);
      t.sa = sign_a_i; t.sb = sign_b_i; t.sub = sub_i; t.ld = load_i;
      t.pr = prod_round_i; t.ps = prod_sat_i; t.ar = acc_round_i; t.as = acc_sat_i;
      q.push_back(t);
      retire(q.pop_front());
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("data_o (R2 R3 R4 R5 R7 R10)", longint'(data_o), exp_data);
    chk("overflow_o (R8)", longint'(overflow_o), longint'(exp_ovf));
    chk("prod_sat_o (R6)", longint'(prod_sat_o), longint'(exp_psat));
    chk("acc_sat_o (R7)", longint'(acc_sat_o), longint'(exp_asat));
  endtask

  task automatic tick(txn_t t, bit en = 1'b1);
    ena_i = en;
    a_i = t.a[17:0]; b_i = t.b[17:0]; load_upper_i = t.up[17:0];
    sign_a_i = t.sa; sign_b_i = t.sb; sub_i = t.sub; load_i = t.ld;
    prod_round_i = t.pr; prod_sat_i = t.ps; acc_round_i = t.ar; acc_sat_i = t.as;
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    txn_t z;
    logic [51:0] held;
    z = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("reset data_o (R1)", longint'(data_o), 0);
    chk("reset flags (R1)", longint'({overflow_o, prod_sat_o, acc_sat_o}), 0);
    rst_ni = 1'b1;

    // R2 R10: signed accumulate, then mixed and unsigned operands
    tick(mk(-3, 1000, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    tick(mk(7, -20, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    tick(mk(-131072, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    tick(mk('h3FFFF, 'h3FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    tick(mk('h3FFFF, 2, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    // R3: subtract
    tick(mk(100, 100, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    tick(mk(-50, 9, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    // R4: load with preset
    tick(mk(3, 4, 1, 1, 0, 1, 'h2A5A5, 0, 0, 0, 0));
    tick(mk(3, 4, 0, 0, 1, 1, 'h15A5A, 0, 0, 0, 0));
    // R5: product rounding
    tick(mk(1, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0));
    tick(mk(181, 91, 1, 1, 0, 0, 0, 1, 0, 0, 0));
    tick(mk(-181, 181, 1, 1, 0, 0, 0, 1, 0, 0, 0));
    tick(mk(128, 128, 1, 1, 0, 0, 0, 1, 0, 0, 0));
    // R6: product clamp both limits
    tick(mk(-131072, -131072, 1, 1, 0, 1, 0, 0, 1, 0, 0));
    tick(mk(-131072, 131071, 1, 1, 0, 0, 0, 1, 1, 0, 0));
    tick(mk(1000, 1000, 1, 1, 0, 0, 0, 0, 1, 0, 0));
    // R7: output round/clamp, running sum untouched
    tick(mk(-131072, -131072, 1, 1, 0, 1, 0, 0, 0, 1, 1));
    tick(mk(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    tick(mk(-131072, -131072, 1, 1, 1, 1, 0, 0, 0, 0, 1));
    tick(mk(3, 5461, 1, 1, 0, 1, 0, 0, 0, 1, 0));
    // R8: signed overflow, sticky, cleared by load
    tick(mk(-131072, -131072, 1, 1, 0, 1, 'h1FFFF, 0, 0, 0, 0));
    tick(mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    tick(mk(-131072, -131072, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    tick(mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    tick(mk(0, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0));
    // R8: unsigned overflow and negative underflow
    tick(mk('h3FFFF, 'h3FFFF, 0, 0, 0, 1, 'h3FFFF, 0, 0, 0, 0));
    tick(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    tick(mk(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0));
    repeat (3) tick(z);
    // R9: enable low holds everything
    tick(mk(77, 77, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    tick(mk(55, 55, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    held = data_o;
    tick(mk(-131072, -131072, 1, 1, 0, 1, 'h1FFFF, 1, 1, 1, 1), 1'b0);
    tick(mk(9, 9, 0, 0, 1, 1, 'h3FFFF, 0, 0, 0, 0), 1'b0);
    chk("data_o held with ena_i low (R9)", longint'(data_o), longint'(held));
    repeat (3) tick(z);

    // mixed random traffic (R2 R3 R4 R6 R7 R8 R10)
    for (int i = 0; i < 400; i++) begin
      txn_t t;
      int r = $urandom;
      t = mk($urandom, $urandom, r[0], r[1], r[2], (r[7:4] == 0), $urandom,
             r[8], r[9], r[10], r[11]);
      tick(t, (r[15:12] != 0));
    end
    repeat (3) tick(z);
    finish_run();
  end
endmodule